// File: doc/BRIEF.md
# Sticky write-protect lock controller

This block guards the writable state of a small register-mapped timekeeping device. It watches every bus write (address, data byte and write strobe) and decides, in the same cycle, whether a write aimed at a protected area may go through. It produces one write-enable qualifier for the counting registers (elapsed time, event count and alarm threshold) and one for a ten-byte user memory.

Each area has its own permanent lock. A lock is set by writing a fixed key byte twice to a dedicated key address. The two writes need not follow each other. A power-on reset between them throws the first one away. Once set, a lock stays set through power-on resets, clear commands and any bus traffic. Only the nonvolatile-initialisation input, which models the factory state of the storage, returns it to 0.

The block also holds a reset-enable bit in a configuration byte. A clear command turns into a one-cycle clear pulse only when that bit is 1 and the counting registers are not locked.

Top module: `wp_lock_ctrl`

## Requirements
- R1: Two writes of byte 0xAA to address 0x1E set `data_lock`. It reads 1 from the cycle after the clock edge that samples the second write.
- R2: Two writes of byte 0xF0 to address 0x1F set `mem_lock`. It reads 1 from the cycle after the clock edge that samples the second write.
- R3: The two key writes may be separated by any other writes. A write of any other byte to a key address neither counts toward the lock nor cancels a first key write already seen.
- R4: A power-on reset (`por_n` low) between the first and second key write discards the first one, so two new key writes are needed.
- R5: Once set, each lock stays 1 through `por_n`, clear commands and all writes. Only `nv_init` high returns both locks to 0.
- R6: `data_we` equals `wr_en` for addresses 0x01 to 0x0A (elapsed time 0x01 to 0x04, event count 0x05 to 0x06, alarm 0x07 to 0x0A) while `data_lock` is 0, and is 0 while `data_lock` is 1. It is combinational in the same cycle.
- R7: `mem_we` equals `wr_en` for addresses 0x0B to 0x14 while `mem_lock` is 0, and is 0 while `mem_lock` is 1. It is combinational in the same cycle.
- R8: A write to address 0x00 loads data bit 0 into `rst_en`, whatever the lock state. `por_n` clears `rst_en`. A one-cycle `clr_cmd` gives a one-cycle `clr_pulse` in the next cycle only if `rst_en` is 1 and `data_lock` is 0; otherwise no pulse appears.
- R9: Writes to any other address (0x00 and 0x15 to 0x1F) raise neither `data_we` nor `mem_we`. The two enables are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; clears sequence progress, `rst_en` and `clr_pulse` |
| nv_init | input | 1 | Nonvolatile initialisation, active high; the only way to clear the locks |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 5 | Bus write address |
| wr_data | input | 8 | Bus write data |
| clr_cmd | input | 1 | Clear command request |
| data_lock | output | 1 | Counting-register lock flag |
| mem_lock | output | 1 | User-memory lock flag |
| rst_en | output | 1 | Reset-enable configuration bit |
| data_we | output | 1 | Qualified write enable for the counting registers |
| mem_we | output | 1 | Qualified write enable for the user memory |
| clr_pulse | output | 1 | Gated clear pulse |

## Verification
The assertions check on every cycle that neither lock ever falls back to 0 without `nv_init`, and that no lock rises unless a key write arrives while its first-write flag is already set. They also check that a locked area never sees a write enable, that the two enables are never high together, and that every clear pulse traces back to a permitted command. Only the bench scenarios can show the sequences that stretch over many cycles. These include key writes with unrelated writes and wrong bytes between them, a power-on reset that abandons a half-done sequence, and locks that survive resets while `nv_init` clears them.

// File: rtl/wp_lock_pkg.sv
package wp_lock_pkg;

  // Address-window test shared by the region decoder.
  function automatic logic in_window(input int unsigned addr,
                                     input int unsigned base,
                                     input int unsigned len);
    return (addr >= base) && (addr < base + len);
  endfunction

  // Next state of a two-write lock sequencer.
  typedef struct packed {
    logic armed;
    logic locked;
  } seq_state_t;

  function automatic seq_state_t seq_next(input seq_state_t cur,
                                          input logic key_hit);
    seq_state_t nxt;
    nxt = cur;
    if (key_hit) begin
      if (cur.armed) nxt.locked = 1'b1;
      nxt.armed = 1'b1;
    end
    return nxt;
  endfunction

endpackage

// File: rtl/wp_seq_lock.sv
module wp_seq_lock #(
  parameter int unsigned     AW       = 5,
  parameter int unsigned     DW       = 8,
  parameter logic [AW-1:0]   KEY_ADDR = '0,
  parameter logic [DW-1:0]   KEY_BYTE = '0
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          nv_init,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          key_hit,
  output logic          armed,
  output logic          locked
);
  import wp_lock_pkg::*;

  seq_state_t cur_s, nxt_s;

  assign key_hit = wr_en && (wr_addr == KEY_ADDR) && (wr_data == KEY_BYTE);
  assign cur_s   = '{armed: armed, locked: locked};
  assign nxt_s   = seq_next(cur_s, key_hit);

  // First-write flag: volatile, lost on power-on reset.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) armed <= 1'b0;
    else        armed <= nxt_s.armed;
  end

  // Lock flag: survives power-on reset, cleared only by nonvolatile init.
  always_ff @(posedge clk or posedge nv_init) begin
    if (nv_init) locked <= 1'b0;
    else         locked <= nxt_s.locked;
  end

endmodule

// File: rtl/wp_region_gate.sv
module wp_region_gate #(
  parameter int unsigned AW       = 5,
  parameter int unsigned CFG_ADDR = 0,
  parameter int unsigned ETC_BASE = 1,
  parameter int unsigned ETC_LEN  = 4,
  parameter int unsigned EVT_BASE = 5,
  parameter int unsigned EVT_LEN  = 2,
  parameter int unsigned ALM_BASE = 7,
  parameter int unsigned ALM_LEN  = 4,
  parameter int unsigned MEM_BASE = 11,
  parameter int unsigned MEM_LEN  = 10
) (
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          data_lock,
  input  logic          mem_lock,
  output logic          data_hit,
  output logic          mem_hit,
  output logic          cfg_hit,
  output logic          data_we,
  output logic          mem_we
);
  import wp_lock_pkg::*;

  localparam int unsigned NREG = 3;
  localparam int unsigned BASES [NREG] = '{ETC_BASE, EVT_BASE, ALM_BASE};
  localparam int unsigned LENS  [NREG] = '{ETC_LEN,  EVT_LEN,  ALM_LEN};

  logic [NREG-1:0] sub_hit;
  int unsigned     addr_i;

  assign addr_i = 32'(wr_addr);

  for (genvar g = 0; g < NREG; g++) begin : g_sub
    assign sub_hit[g] = in_window(addr_i, BASES[g], LENS[g]);
  end

  assign data_hit = |sub_hit;
  assign mem_hit  = in_window(addr_i, MEM_BASE, MEM_LEN);
  assign cfg_hit  = (addr_i == CFG_ADDR);

  assign data_we  = wr_en && data_hit && !data_lock;
  assign mem_we   = wr_en && mem_hit  && !mem_lock;

endmodule

// File: rtl/wp_clr_gate.sv
module wp_clr_gate (
  input  logic clk,
  input  logic por_n,
  input  logic cfg_wr,
  input  logic cfg_bit,
  input  logic clr_cmd,
  input  logic data_lock,
  output logic clr_ok,
  output logic rst_en,
  output logic clr_pulse
);

  assign clr_ok = clr_cmd && rst_en && !data_lock;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rst_en    <= 1'b0;
      clr_pulse <= 1'b0;
    end else begin
      if (cfg_wr) rst_en <= cfg_bit;
      clr_pulse <= clr_ok;
    end
  end

endmodule

// File: rtl/wp_lock_ctrl.sv
module wp_lock_ctrl #(
  parameter int unsigned   AW        = 5,
  parameter int unsigned   DW        = 8,
  parameter int unsigned   CFG_ADDR  = 0,
  parameter int unsigned   RE_BIT    = 0,
  parameter int unsigned   ETC_BASE  = 1,
  parameter int unsigned   ETC_LEN   = 4,
  parameter int unsigned   EVT_BASE  = 5,
  parameter int unsigned   EVT_LEN   = 2,
  parameter int unsigned   ALM_BASE  = 7,
  parameter int unsigned   ALM_LEN   = 4,
  parameter int unsigned   MEM_BASE  = 11,
  parameter int unsigned   MEM_LEN   = 10,
  parameter logic [AW-1:0] DKEY_ADDR = 5'h1E,
  parameter logic [DW-1:0] DKEY_BYTE = 8'hAA,
  parameter logic [AW-1:0] MKEY_ADDR = 5'h1F,
  parameter logic [DW-1:0] MKEY_BYTE = 8'hF0
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          nv_init,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          clr_cmd,
  output logic          data_lock,
  output logic          mem_lock,
  output logic          rst_en,
  output logic          data_we,
  output logic          mem_we,
  output logic          clr_pulse
);

  // Named internal events, brought out for the checker.
  logic data_key_hit, data_armed;
  logic mem_key_hit,  mem_armed;
  logic data_hit, mem_hit, cfg_hit;
  logic clr_ok;

  wp_seq_lock #(.AW(AW), .DW(DW), .KEY_ADDR(DKEY_ADDR), .KEY_BYTE(DKEY_BYTE)) u_data_seq (
    .clk(clk), .por_n(por_n), .nv_init(nv_init),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .key_hit(data_key_hit), .armed(data_armed), .locked(data_lock)
  );

  wp_seq_lock #(.AW(AW), .DW(DW), .KEY_ADDR(MKEY_ADDR), .KEY_BYTE(MKEY_BYTE)) u_mem_seq (
    .clk(clk), .por_n(por_n), .nv_init(nv_init),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .key_hit(mem_key_hit), .armed(mem_armed), .locked(mem_lock)
  );

  wp_region_gate #(
    .AW(AW), .CFG_ADDR(CFG_ADDR),
    .ETC_BASE(ETC_BASE), .ETC_LEN(ETC_LEN),
    .EVT_BASE(EVT_BASE), .EVT_LEN(EVT_LEN),
    .ALM_BASE(ALM_BASE), .ALM_LEN(ALM_LEN),
    .MEM_BASE(MEM_BASE), .MEM_LEN(MEM_LEN)
  ) u_gate (
    .wr_en(wr_en), .wr_addr(wr_addr),
    .data_lock(data_lock), .mem_lock(mem_lock),
    .data_hit(data_hit), .mem_hit(mem_hit), .cfg_hit(cfg_hit),
    .data_we(data_we), .mem_we(mem_we)
  );

  wp_clr_gate u_clr (
    .clk(clk), .por_n(por_n),
    .cfg_wr(wr_en && cfg_hit), .cfg_bit(wr_data[RE_BIT]),
    .clr_cmd(clr_cmd), .data_lock(data_lock),
    .clr_ok(clr_ok), .rst_en(rst_en), .clr_pulse(clr_pulse)
  );

endmodule

// File: rtl/wp_lock_chk.sv
module wp_lock_chk (
  input logic clk,
  input logic por_n,
  input logic nv_init,
  input logic clr_cmd,
  input logic data_lock,
  input logic mem_lock,
  input logic data_key_hit,
  input logic data_armed,
  input logic mem_key_hit,
  input logic mem_armed,
  input logic rst_en,
  input logic data_we,
  input logic mem_we,
  input logic clr_pulse
);

  p_data_lock_sticky_r5: assert property (@(posedge clk) disable iff (nv_init || !por_n)
    data_lock |=> data_lock);

  p_mem_lock_sticky_r5: assert property (@(posedge clk) disable iff (nv_init || !por_n)
    mem_lock |=> mem_lock);

  p_data_lock_two_writes_r1: assert property (@(posedge clk) disable iff (nv_init || !por_n)
    (!data_lock && !(data_key_hit && data_armed)) |=> !data_lock);

  p_mem_lock_two_writes_r2: assert property (@(posedge clk) disable iff (nv_init || !por_n)
    (!mem_lock && !(mem_key_hit && mem_armed)) |=> !mem_lock);

  p_data_we_blocked_r6: assert property (@(posedge clk) disable iff (nv_init || !por_n)
    data_lock |-> !data_we);

  p_mem_we_blocked_r7: assert property (@(posedge clk) disable iff (nv_init || !por_n)
    mem_lock |-> !mem_we);

  p_clr_permitted_r8: assert property (@(posedge clk) disable iff (nv_init || !por_n)
    clr_pulse |-> $past(clr_cmd && rst_en && !data_lock));

  p_we_exclusive_r9: assert property (@(posedge clk) disable iff (nv_init || !por_n)
    $countones({data_we, mem_we}) <= 1);

endmodule

bind wp_lock_ctrl wp_lock_chk u_wp_lock_chk (
  .clk(clk), .por_n(por_n), .nv_init(nv_init), .clr_cmd(clr_cmd),
  .data_lock(data_lock), .mem_lock(mem_lock),
  .data_key_hit(data_key_hit), .data_armed(data_armed),
  .mem_key_hit(mem_key_hit), .mem_armed(mem_armed),
  .rst_en(rst_en), .data_we(data_we), .mem_we(mem_we), .clr_pulse(clr_pulse)
);

// File: tb/test_wp_lock_ctrl.sv
module test_wp_lock_ctrl;
  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       nv_init = 1'b1;
  logic       wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       clr_cmd = 1'b0;
  logic       data_lock, mem_lock, rst_en, data_we, mem_we, clr_pulse;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic seen_dwe, seen_mwe;

  always #4 clk = ~clk;  // 125 MHz

  wp_lock_ctrl i_wp_lock_ctrl (
    .clk(clk), .por_n(por_n), .nv_init(nv_init),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .clr_cmd(clr_cmd),
    .data_lock(data_lock), .mem_lock(mem_lock), .rst_en(rst_en),
    .data_we(data_we), .mem_we(mem_we), .clr_pulse(clr_pulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One bus write; captures the combinational enables during it.
  task automatic bus_wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    #1;
    seen_dwe = data_we; seen_mwe = mem_we;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic power_cycle();
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
  endtask

  // Issues a one-cycle clear command and checks the pulse.
  task automatic clear_try(input string req, input int exp);
    @(negedge clk); clr_cmd = 1'b1;
    @(posedge clk); #1;
    chk(req, clr_pulse, exp);
    @(negedge clk); clr_cmd = 1'b0;
    @(posedge clk); #1;
    chk(req, clr_pulse, 0);
  endtask

  task automatic t_reset();
    #1;
    chk("R5 nv_init clears data_lock", data_lock, 0);
    chk("R5 nv_init clears mem_lock", mem_lock, 0);
    chk("R8 rst_en after por", rst_en, 0);
    chk("R8 clr_pulse after por", clr_pulse, 0);
  endtask

  task automatic t_regions_open();
    bus_wr(5'h03, 8'h11);
    chk("R6 etc write allowed", seen_dwe, 1); chk("R9 mem_we on etc", seen_mwe, 0);
    bus_wr(5'h06, 8'h12);
    chk("R6 event write allowed", seen_dwe, 1);
    bus_wr(5'h0A, 8'h13);
    chk("R6 alarm write allowed", seen_dwe, 1);
    bus_wr(5'h0B, 8'h14);
    chk("R7 mem low write allowed", seen_mwe, 1); chk("R9 data_we on mem", seen_dwe, 0);
    bus_wr(5'h14, 8'h15);
    chk("R7 mem high write allowed", seen_mwe, 1);
    bus_wr(5'h15, 8'h16);
    chk("R9 addr 0x15 data_we", seen_dwe, 0); chk("R9 addr 0x15 mem_we", seen_mwe, 0);
    bus_wr(5'h1E, 8'h00);
    chk("R9 key addr data_we", seen_dwe, 0); chk("R9 key addr mem_we", seen_mwe, 0);
  endtask

  task automatic t_clear_gate();
    clear_try("R8 clear with rst_en=0", 0);
    bus_wr(5'h00, 8'h01);
    chk("R8 rst_en set by config write", rst_en, 1);
    clear_try("R8 clear with rst_en=1 unlocked", 1);
    bus_wr(5'h00, 8'hFE);
    chk("R8 rst_en cleared by config write", rst_en, 0);
  endtask

  task automatic t_por_abandons();
    bus_wr(5'h1E, 8'hAA);
    power_cycle();
    bus_wr(5'h1E, 8'hAA);
    chk("R4 power cycle discards first key write", data_lock, 0);
    power_cycle();
  endtask

  task automatic t_data_lock();
    bus_wr(5'h1E, 8'h55);
    bus_wr(5'h1E, 8'hAA);
    chk("R3 wrong byte does not count", data_lock, 0);
    bus_wr(5'h02, 8'h77);
    bus_wr(5'h1E, 8'h00);
    chk("R3 wrong byte does not complete", data_lock, 0);
    bus_wr(5'h1E, 8'hAA);
    chk("R1 second key write sets data_lock", data_lock, 1);
    chk("R1 mem_lock untouched", mem_lock, 0);
    bus_wr(5'h03, 8'h01);
    chk("R6 locked etc write blocked", seen_dwe, 0);
    bus_wr(5'h09, 8'h01);
    chk("R6 locked alarm write blocked", seen_dwe, 0);
    bus_wr(5'h0C, 8'h01);
    chk("R7 mem still writable", seen_mwe, 1);
    bus_wr(5'h00, 8'h01);
    chk("R8 config writable while locked", rst_en, 1);
    clear_try("R8 clear blocked by data_lock", 0);
    power_cycle();
    chk("R5 data_lock survives por", data_lock, 1);
    chk("R8 por clears rst_en", rst_en, 0);
    bus_wr(5'h1E, 8'h00);
    clear_try("R5 data_lock survives clear", 0);
    chk("R5 data_lock after writes and clear", data_lock, 1);
  endtask

  task automatic t_mem_lock();
    bus_wr(5'h1F, 8'hAA);
    bus_wr(5'h1F, 8'hF0);
    bus_wr(5'h05, 8'h01);
    chk("R3 unrelated write between key writes", mem_lock, 0);
    bus_wr(5'h1F, 8'hF0);
    chk("R2 second key write sets mem_lock", mem_lock, 1);
    bus_wr(5'h14, 8'h01);
    chk("R7 locked mem high blocked", seen_mwe, 0);
    bus_wr(5'h0B, 8'h01);
    chk("R7 locked mem low blocked", seen_mwe, 0);
    power_cycle();
    chk("R5 mem_lock survives por", mem_lock, 1);
  endtask

  task automatic t_nv_init();
    @(negedge clk); nv_init = 1'b1;
    @(negedge clk); nv_init = 1'b0;
    #1;
    chk("R5 nv_init clears data_lock", data_lock, 0);
    chk("R5 nv_init clears mem_lock", mem_lock, 0);
    bus_wr(5'h04, 8'h01);
    chk("R6 write allowed after nv_init", seen_dwe, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1; nv_init = 1'b0;
    t_reset();
    t_regions_open();
    t_clear_gate();
    t_por_abandons();
    t_data_lock();
    t_mem_lock();
    t_nv_init();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule